// File: doc/BRIEF.md
# Burst-mode CPU clock throttle

This block reduces processor power by thinning out the processor clock. It drives a clock-enable for a glitch-free gating cell. While throttling is off, the enable stays high. While throttling is on, time is split into frames of 31 periods of a slow 32.768 kHz reference. In each frame the processor clock runs for a programmable number of reference periods, called the burst, and is held off for the rest of the frame. A burst length of zero stops the processor altogether (doze). A wake-up event ends throttling at once in hardware, and software has to arm it again afterwards.

The processor is parked only while the DMA side owns the bus. Before the enable drops, the block raises a bus request towards the processor. The clock is removed only once the grant comes back. DMA always has priority on the bus. When the enable is about to return, the block waits until any DMA transfer in progress has finished. The reference arrives as a free-running level and is synchronised inside the block. Software sets the enable bit and the burst field with a single write strobe. There is no data stream in this block, so every pin is a plain level or strobe. The request/grant pair is a four-phase handshake: the request stays high until the block has finished with the bus.

Top module: `cpu_burst_gate`

## Requirements
- R1: With throttling on and a burst field b in 1..30, the enable pattern repeats every 31 reference periods. In each frame the enable is high for b reference periods plus one system clock cycle, and low for the remainder. Each reference period is counted once, on its rising edge after a two-flop synchroniser.
- R2: With throttling on and b = 0, the enable stays low for the whole frame (doze).
- R3: With throttling on and b ≥ 31, the enable stays high.
- R4: Writing the enable bit to 0 returns the enable to continuous high within two cycles when no DMA transfer is in progress. The enable then stays high.
- R5: A wake-up pulse clears the throttle status in the next cycle. It wins over a write that sets the enable bit in the same cycle.
- R6: The enable falls only in the cycle after `bus_gnt_i` was sampled high. `bus_req_o` is high whenever the enable is low.
- R7: After throttling ends while the clock is held off, the enable stays low as long as `dma_busy_i` is high. It rises within two cycles after `dma_busy_i` drops.
- R8: A burst field written while throttling is already on takes effect only from the next frame boundary.
- R9: Setting the enable bit from 0 restarts the frame count at zero. The first gating therefore begins b reference periods after the write, up to one reference period and the synchroniser delay later.
- R10: While reset is held, the enable is high, `bus_req_o` is low and `thr_active_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | 32.768 kHz reference level, asynchronous to clk |
| ctl_wr_i | input | 1 | Write strobe for the control fields |
| ctl_en_i | input | 1 | Enable bit value written with the strobe |
| ctl_width_i | input | 5 | Burst length in reference periods |
| wake_i | input | 1 | Wake-up event pulse |
| bus_gnt_i | input | 1 | Bus grant from the processor |
| dma_busy_i | input | 1 | DMA transfer in progress |
| cpu_clk_en_o | output | 1 | Enable for the processor clock gating cell |
| bus_req_o | output | 1 | Bus request to the processor |
| thr_active_o | output | 1 | Throttling is enabled |

## Verification
The bench sweeps every burst value from 0 to 31 and measures the on-time over one whole frame. A wrong frame length, an off-by-one on the burst comparison, or a bad saturation at 31 shows up as a wrong count. A burst field rewritten in mid-frame is checked against both the current frame and the following one. A design that applies the new value at once ends the current burst early or late. A wake-up is issued while the processor is parked and a DMA transfer is still running. A design that restores the clock early gives the processor a clock while DMA still holds the bus, and a design that forgets to clear the enable bit keeps throttling. The delay from first arming to the first gating is measured to catch a frame counter that is not restarted.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  // Handshake states of the gating sequencer
  typedef enum logic [1:0] {
    GS_RUN  = 2'd0,  // processor clocked, bus not requested
    GS_ASK  = 2'd1,  // bus requested, still clocked
    GS_HELD = 2'd2   // bus granted, processor clock off
  } gate_state_e;

  localparam int unsigned FRAME_LEN_DEF = 31;
  localparam int unsigned WIDTH_BITS_DEF = 5;
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/cbg_tick_sync.sv
module cbg_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_i;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cbg_frame.sv
module cbg_frame #(
  parameter int unsigned FRAME_LEN  = 31,
  parameter int unsigned WIDTH_BITS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  active_i,
  input  logic                  restart_i,
  input  logic [WIDTH_BITS-1:0] width_now_i,
  input  logic [WIDTH_BITS-1:0] width_next_i,
  output logic                  want_off_o
);
  localparam logic [WIDTH_BITS-1:0] LAST_POS = WIDTH_BITS'(FRAME_LEN - 1);
  localparam logic [WIDTH_BITS-1:0] FULL_W   = WIDTH_BITS'(FRAME_LEN);

  logic [WIDTH_BITS-1:0] pos_q;
  logic [WIDTH_BITS-1:0] burst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      burst_q <= '0;
    end else if (restart_i) begin
      pos_q   <= '0;
      burst_q <= width_now_i;
    end else if (tick_i) begin
      if (pos_q == LAST_POS) begin
        pos_q   <= '0;
        burst_q <= width_next_i;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign want_off_o = active_i && (burst_q < FULL_W) && (pos_q >= burst_q);
endmodule

// File: rtl/cbg_handshake.sv
module cbg_handshake
  import cbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want_off_i,
  input  logic gnt_i,
  input  logic dma_busy_i,
  output logic clk_en_o,
  output logic req_o
);
  gate_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_RUN:  if (want_off_i) st_d = GS_ASK;
      GS_ASK:  if (!want_off_i) st_d = GS_RUN;
               else if (gnt_i) st_d = GS_HELD;
      GS_HELD: if (!want_off_i && !dma_busy_i) st_d = GS_RUN;
      default: st_d = GS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GS_RUN;
    else        st_q <= st_d;
  end

  // Outputs come straight from the state flop, so they change only after a rising edge
  assign clk_en_o = (st_q != GS_HELD);
  assign req_o    = (st_q != GS_RUN);
endmodule

// File: rtl/cpu_burst_gate.sv
module cpu_burst_gate
  import cbg_pkg::*;
#(
  parameter int unsigned FRAME_LEN   = FRAME_LEN_DEF,
  parameter int unsigned WIDTH_BITS  = WIDTH_BITS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ref_clk_i,
  input  logic                  ctl_wr_i,
  input  logic                  ctl_en_i,
  input  logic [WIDTH_BITS-1:0] ctl_width_i,
  input  logic                  wake_i,
  input  logic                  bus_gnt_i,
  input  logic                  dma_busy_i,
  output logic                  cpu_clk_en_o,
  output logic                  bus_req_o,
  output logic                  thr_active_o
);
  logic                  active_q;
  logic [WIDTH_BITS-1:0] width_pend_q;
  logic                  tick;
  logic                  restart;
  logic                  want_off;

  // First arming of the throttle restarts the frame; a wake-up overrides the write
  assign restart = ctl_wr_i && ctl_en_i && !active_q && !wake_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      width_pend_q <= '0;
    end else begin
      if (wake_i)        active_q <= 1'b0;
      else if (ctl_wr_i) active_q <= ctl_en_i;
      if (ctl_wr_i)      width_pend_q <= ctl_width_i;
    end
  end

  cbg_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ref_clk_i),
    .rise_o  (tick)
  );

  cbg_frame #(.FRAME_LEN(FRAME_LEN), .WIDTH_BITS(WIDTH_BITS)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .active_i     (active_q),
    .restart_i    (restart),
    .width_now_i  (ctl_width_i),
    .width_next_i (width_pend_q),
    .want_off_o   (want_off)
  );

  cbg_handshake u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_off_i (want_off),
    .gnt_i      (bus_gnt_i),
    .dma_busy_i (dma_busy_i),
    .clk_en_o   (cpu_clk_en_o),
    .req_o      (bus_req_o)
  );

  assign thr_active_o = active_q;
endmodule

// File: rtl/cpu_burst_gate_chk.sv
module cpu_burst_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic wake_i,
  input logic bus_gnt_i,
  input logic dma_busy_i,
  input logic cpu_clk_en_o,
  input logic bus_req_o,
  input logic thr_active_o
);
  // R6
  gate_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en_o) |-> $past(bus_gnt_i));
  // R6
  req_while_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en_o |-> bus_req_o);
  // R5
  wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> !thr_active_o);
  // R7
  dma_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en_o) |-> !$past(dma_busy_i));
  // R4
  idle_stays_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_active_o && cpu_clk_en_o) |=> cpu_clk_en_o);
endmodule

bind cpu_burst_gate cpu_burst_gate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wake_i       (wake_i),
  .bus_gnt_i    (bus_gnt_i),
  .dma_busy_i   (dma_busy_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .bus_req_o    (bus_req_o),
  .thr_active_o (thr_active_o)
);

// File: tb/test_cpu_burst_gate.sv
module test_cpu_burst_gate;
  localparam int TP    = 8;   // system cycles per reference period
  localparam int FRAME = 31 * TP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       ctl_wr = 1'b0;
  logic       ctl_en = 1'b0;
  logic [4:0] ctl_width = '0;
  logic       wake = 1'b0;
  logic       bus_gnt = 1'b0;
  logic       dma_busy = 1'b0;
  logic       cpu_clk_en, bus_req, thr_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cpu_burst_gate i_cpu_burst_gate (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk),
    .ctl_wr_i(ctl_wr), .ctl_en_i(ctl_en), .ctl_width_i(ctl_width),
    .wake_i(wake), .bus_gnt_i(bus_gnt), .dma_busy_i(dma_busy),
    .cpu_clk_en_o(cpu_clk_en), .bus_req_o(bus_req), .thr_active_o(thr_active)
  );

  always #2 clk = ~clk;

  // reference level: TP/2 cycles high, TP/2 low
  initial forever begin
    repeat (TP/2) @(negedge clk);
    ref_clk = ~ref_clk;
  end

  // processor model: grants the bus one cycle after the request
  initial forever begin
    @(negedge clk);
    bus_gnt = bus_req;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic cfg(input bit en, input int w);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_en = en; ctl_width = 5'(w);
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // count negedges until the enable reaches the given level
  task automatic wait_en(input bit lvl, output int n);
    n = 0;
    while (cpu_clk_en !== lvl && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  int n, hi, exp_on;
  bit ok;

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cpu_clk_en === 1'b1, "R10 en", int'(cpu_clk_en), 1);
    chk(bus_req === 1'b0, "R10 req", int'(bus_req), 0);
    chk(thr_active === 1'b0, "R10 active", int'(thr_active), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2 R3 sweep of every burst value
    for (int w = 0; w < 32; w++) begin
      cfg(1'b0, 0);
      repeat (5) @(negedge clk);
      cfg(1'b1, w);
      repeat (2 * FRAME) @(negedge clk);
      hi = 0;
      for (int k = 0; k < FRAME; k++) begin
        @(negedge clk);
        if (cpu_clk_en) hi++;
      end
      exp_on = (w == 0) ? 0 : (w >= 31) ? FRAME : w * TP + 1;
      if (w == 0)       chk(hi == exp_on, "R2 doze", hi, exp_on);
      else if (w >= 31) chk(hi == exp_on, "R3 full", hi, exp_on);
      else              chk(hi == exp_on, "R1 burst", hi, exp_on);
    end

    // R9 first arming restarts the frame
    cfg(1'b0, 0);
    repeat (37) @(negedge clk);
    cfg(1'b1, 10);
    wait_en(1'b0, n);
    ok = (n >= 10 * TP - 2) && (n <= 11 * TP + 6);
    chk(ok, "R9 first gate delay", n, 10 * TP);

    // R8 burst change applies at the next frame
    cfg(1'b0, 0);
    repeat (5) @(negedge clk);
    cfg(1'b1, 5);
    wait_en(1'b1, n);
    wait_en(1'b0, n);
    wait_en(1'b1, n);
    wait_en(1'b0, n);
    chk(n == 5 * TP + 1, "R8 before change", n, 5 * TP + 1);
    repeat (20) @(negedge clk);
    cfg(1'b1, 20);
    wait_en(1'b1, n);
    chk(n > 100, "R8 off span kept", n, 31 * TP - 5 * TP - 1);
    wait_en(1'b0, n);
    chk(n == 20 * TP + 1, "R8 after change", n, 20 * TP + 1);

    // R4 clearing the enable bit while parked
    cfg(1'b1, 3);
    wait_en(1'b0, n);
    repeat (10) @(negedge clk);
    cfg(1'b0, 3);
    wait_en(1'b1, n);
    chk(n <= 2, "R4 resume delay", n, 2);
    hi = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (cpu_clk_en) hi++;
    end
    chk(hi == 300, "R4 continuous", hi, 300);

    // R5 R7 wake-up while parked with DMA running
    cfg(1'b1, 3);
    wait_en(1'b0, n);
    repeat (5) @(negedge clk);
    dma_busy = 1'b1;
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk(thr_active === 1'b0, "R5 wake clears", int'(thr_active), 0);
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cpu_clk_en) hi++;
    end
    chk(hi == 0, "R7 held while DMA busy", hi, 0);
    chk(bus_req === 1'b1, "R6 request kept", int'(bus_req), 1);
    dma_busy = 1'b0;
    wait_en(1'b1, n);
    chk(n <= 2, "R7 resume after DMA", n, 2);
    hi = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (cpu_clk_en) hi++;
    end
    chk(hi == 300, "R5 continuous after wake", hi, 300);

    // R5 wake beats a simultaneous arming write
    @(negedge clk);
    ctl_wr = 1'b1; ctl_en = 1'b1; ctl_width = 5'd0; wake = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; wake = 1'b0;
    chk(thr_active === 1'b0, "R5 wake priority", int'(thr_active), 0);
    hi = 0;
    for (int k = 0; k < FRAME; k++) begin
      @(negedge clk);
      if (cpu_clk_en) hi++;
    end
    chk(hi == FRAME, "R5 no doze after wake", hi, FRAME);

    // R6 doze entry waits for the grant
    cfg(1'b1, 0);
    @(negedge clk);
    chk(bus_req === 1'b1 && cpu_clk_en === 1'b1, "R6 request before gate",
        int'(cpu_clk_en), 1);
    @(negedge clk);
    chk(cpu_clk_en === 1'b0, "R6 gated after grant", int'(cpu_clk_en), 0);
    cfg(1'b0, 0);
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule